// File: doc/BRIEF.md
# Lockable Security Control Register Bank

This block is a small 32-bit register bank that holds a security and configuration control word for the rest of the chip. Software programs the control word through a simple word-wide write/read port, then sets bits in a sticky lock register. Each lock bit freezes one group of control fields, and a frozen field keeps its value until reset. A lock bit can be set but never cleared.

An unlock register acts as a tripwire. Writing the one accepted key word does nothing. Any other word clears the configuration-enable bit (bit 27) and the cipher-enable field (bits 11:9) of the control word. It then shuts the whole register window until reset: reads return zero and writes are dropped.

The bank also holds an interrupt status register with write-one-to-clear bits and an interrupt mask register. Together they drive a registered, level-sensitive interrupt output. Hardware events set status bits directly.

Top module: `secctl_regbank`

## Requirements
- R1: After reset the control word is 0x0C006000 (bits 27, 26, 14 and 13 set), the lock register is 0, the status register is 0, the mask register is 0xFFFFFFFF, and both the interrupt output and the read data are 0.
- R2: A write to the lock register ORs the written value into its current value, so a set lock bit stays set until reset. Only lock bits 4:0 exist, and bits 31:5 always read 0.
- R3: On a control write, each field covered by a set lock bit keeps its old value. The groups are: lock bit 4 covers control bit 12; lock bit 3 covers bits 11:9; lock bit 2 covers bit 8; lock bit 1 covers bit 7; lock bit 0 covers bits 6:0.
- R4: On a control write, every writable bit that no set lock bit covers takes the written value.
- R5: Control bits 31 and 28 cannot be written and always read 0.
- R6: Writing 0x757BDF0D to the unlock register changes no state.
- R7: Writing any other value to the unlock register clears control bit 27 and bits 11:9, whatever the lock state. From the next cycle until reset, every read returns 0 and every write is ignored. Hardware status events and the interrupt output keep working.
- R8: The interrupt output is a register that holds the OR of (status AND NOT mask). It reflects a status write, a mask write or a hardware event from the clock edge that performs the update.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: A hardware set event on a status bit wins over a write-one-to-clear of the same bit in the same cycle, so the bit ends up set.
- R11: Only accesses with address bits 1:0 equal to 00 are valid. A misaligned write changes nothing, and a misaligned read returns 0.
- R12: The byte offsets are: control 0x00, lock 0x04, status 0x08, mask 0x0C, unlock 0x10. The unlock register and all other offsets read 0. Read data appears on the cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data for the address of the previous cycle |
| hw_status_set | input | DW | Per-bit hardware events that set status bits |
| ctrl_o | output | DW | Current control word, driven to the security logic |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The control word is written with all ones and with all zeros under several partial lock states. These patterns separate bits that follow the data from bits held by each lock group, and they show the non-writable bits staying at zero. Lock writes with zero data and with out-of-range bits show whether the lock register ORs, overwrites or truncates. The interrupt path is driven with hardware events alone, with mask changes, with write-one-to-clear alone, and with a clear and an event on the same bit in one cycle; this last case sets hardware priority apart from software priority. Unlock writes use the key and then a wrong word. The control output port then shows the field clearing and the ignored writes, and read-backs return zero while the window is shut.

// File: rtl/secctl_pkg.sv
package secctl_pkg;
  localparam int REG_W  = 32;
  localparam int LOCK_W = 5;

  // word indices of the registers (byte offset / 4)
  localparam int IDX_CTRL   = 0;
  localparam int IDX_LOCK   = 1;
  localparam int IDX_STS    = 2;
  localparam int IDX_MSK    = 3;
  localparam int IDX_UNLOCK = 4;

  localparam logic [REG_W-1:0] CTRL_RST     = 32'h0C00_6000;
  localparam logic [REG_W-1:0] CTRL_RO      = (32'h1 << 31) | (32'h1 << 28);
  localparam logic [REG_W-1:0] BAD_KEY_CLR  = (32'h1 << 27) | (32'h7 << 9);
  localparam logic [REG_W-1:0] UNLOCK_KEY   = 32'h757B_DF0D;

  // control bits held by each lock bit
  function automatic logic [REG_W-1:0] lock_group(input int idx);
    case (idx)
      4:       return 32'h0000_1000;
      3:       return 32'h0000_0E00;
      2:       return 32'h0000_0100;
      1:       return 32'h0000_0080;
      0:       return 32'h0000_007F;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/secctl_lockctl.sv
module secctl_lockctl
  import secctl_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int LW = LOCK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic          lock_we,
  input  logic          unlock_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [LW-1:0] lock_q,
  output logic          blocked_q
);
  logic [LW-1:0][DW-1:0] grp_frz;
  logic [DW-1:0]         frz;
  logic                  bad_unl;

  genvar g;
  generate
    for (g = 0; g < LW; g++) begin : g_grp
      assign grp_frz[g] = lock_q[g] ? lock_group(g) : '0;
    end
  endgenerate

  always_comb begin
    frz = '0;
    for (int i = 0; i < LW; i++) frz = frz | grp_frz[i];
  end

  assign bad_unl = unlock_we && (wdata != UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RST;
      lock_q    <= '0;
      blocked_q <= 1'b0;
    end else begin
      if (bad_unl) begin
        ctrl_q    <= ctrl_q & ~BAD_KEY_CLR;
        blocked_q <= 1'b1;
      end else if (ctrl_we) begin
        ctrl_q <= ((wdata & ~frz) | (ctrl_q & frz)) & ~CTRL_RO;
      end
      if (lock_we) lock_q <= lock_q | wdata[LW-1:0];
    end
  end

  // R2: lock bits never fall
  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (lock_q & $past(lock_q)) == $past(lock_q));

  // R3: frozen fields hold unless the wrong key arrived
  p_frozen_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(bad_unl) |-> (((ctrl_q ^ $past(ctrl_q)) & $past(frz)) == '0));

  // R7: the shut window stays shut
  p_blocked_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    blocked_q |=> blocked_q);
endmodule

// File: rtl/secctl_irq.sv
module secctl_irq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sts_we,
  input  logic          msk_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] sts_q,
  output logic [DW-1:0] msk_q,
  output logic          irq_q
);
  logic [DW-1:0] sts_n, msk_n, clr;

  always_comb begin
    clr   = sts_we ? wdata : '0;
    sts_n = (sts_q & ~clr) | hw_set;
    msk_n = msk_we ? wdata : msk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      msk_q <= '1;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_n;
      msk_q <= msk_n;
      irq_q <= |(sts_n & ~msk_n);
    end
  end

  // R10: an event bit is always set after its edge
  p_hw_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (sts_q & $past(hw_set)) == $past(hw_set));

  // R8: output level matches the stored status and mask
  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|(sts_q & ~msk_q)));
endmodule

// File: rtl/secctl_regbank.sv
module secctl_regbank
  import secctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     hw_status_set,
  output logic [DW-1:0]     ctrl_o,
  output logic              irq_o
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0]     idx;
  logic              acc_ok;
  logic              ctrl_we, lock_we, unl_we, sts_we, msk_we;
  logic [DW-1:0]     ctrl_q, sts_q, msk_q, rd_n;
  logic [LOCK_W-1:0] lock_q;
  logic              blocked_q;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign acc_ok = (bus_addr[1:0] == 2'b00) && !blocked_q;

  assign ctrl_we = bus_wr_en && acc_ok && (idx == IW'(IDX_CTRL));
  assign lock_we = bus_wr_en && acc_ok && (idx == IW'(IDX_LOCK));
  assign sts_we  = bus_wr_en && acc_ok && (idx == IW'(IDX_STS));
  assign msk_we  = bus_wr_en && acc_ok && (idx == IW'(IDX_MSK));
  assign unl_we  = bus_wr_en && acc_ok && (idx == IW'(IDX_UNLOCK));

  secctl_lockctl #(.DW(DW), .LW(LOCK_W)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .ctrl_we   (ctrl_we),
    .lock_we   (lock_we),
    .unlock_we (unl_we),
    .wdata     (bus_wdata),
    .ctrl_q    (ctrl_q),
    .lock_q    (lock_q),
    .blocked_q (blocked_q)
  );

  secctl_irq #(.DW(DW)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .sts_we (sts_we),
    .msk_we (msk_we),
    .wdata  (bus_wdata),
    .hw_set (hw_status_set),
    .sts_q  (sts_q),
    .msk_q  (msk_q),
    .irq_q  (irq_o)
  );

  always_comb begin
    rd_n = '0;
    if (acc_ok) begin
      case (idx)
        IW'(IDX_CTRL): rd_n = ctrl_q;
        IW'(IDX_LOCK): rd_n = DW'(lock_q);
        IW'(IDX_STS):  rd_n = sts_q;
        IW'(IDX_MSK):  rd_n = msk_q;
        default:       rd_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_n;
  end

  assign ctrl_o = ctrl_q;

  // R7: nothing leaks out of a shut window
  p_blocked_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    $past(blocked_q) |-> (bus_rdata == '0));

  // R5: fixed bits of the control word stay low
  p_ro_bits_low_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_o[31] == 1'b0) && (ctrl_o[28] == 1'b0));
endmodule

// File: tb/tb_secctl_regbank.sv
module tb_secctl_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] hw_status_set = '0;
  logic [31:0] ctrl_o;
  logic        irq_o;

  always #2.5 clk = ~clk;

  secctl_regbank dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_status_set(hw_status_set), .ctrl_o(ctrl_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   errors = 0;
  int   checks = 0;
  logic drv_rd = 1'b0;
  logic issued_q = 1'b0;
  bit   done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver tasks: called at a falling edge, return at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a; drv_rd = 1'b1;
    @(negedge clk);
    drv_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: read data is valid one edge after the address
  always @(posedge clk) issued_q <= drv_rd;

  always @(negedge clk) begin
    if (issued_q) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor: read with no expectation actual=%h expected=none", bus_rdata);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        check(it.tag, bus_rdata, it.val);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    check("R1 ctrl_o after reset", ctrl_o, 32'h0C00_6000);
    rd(8'h00, 32'h0C00_6000, "R1 ctrl reset");
    rd(8'h04, 32'h0, "R1 lock reset");
    rd(8'h08, 32'h0, "R1 status reset");
    rd(8'h0C, 32'hFFFF_FFFF, "R1 mask reset");
    rd(8'h10, 32'h0, "R12 unlock reads zero");
    rd(8'h20, 32'h0, "R12 unmapped reads zero");

    // R4 R5 all-ones with no locks
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h6FFF_FFFF, "R4 R5 ctrl all ones");

    // R2 OR behaviour and width
    wr(8'h04, 32'h0000_0004);
    wr(8'h04, 32'h0000_0021);
    rd(8'h04, 32'h0000_0005, "R2 lock OR and truncation");
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, 32'h0000_0005, "R2 lock zero write keeps bits");

    // R3 groups 0 and 2 frozen
    wr(8'h00, 32'h0000_0E00);
    rd(8'h00, 32'h0000_0F7F, "R3 groups 0 and 2 held");

    // R3 R4 more groups
    wr(8'h04, 32'h0000_0018);
    rd(8'h04, 32'h0000_001D, "R2 lock accumulates");
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, 32'h0000_0F7F, "R3 groups 0 2 3 4 held");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h6FFF_EFFF, "R4 free bits follow data");

    // R8 R9 R10 interrupt path
    hw_status_set = 32'h0000_0008;
    @(negedge clk);
    hw_status_set = '0;
    check("R8 masked event no irq", {31'd0, irq_o}, 32'd0);
    rd(8'h08, 32'h0000_0008, "R10 hw event sets status");
    wr(8'h0C, 32'hFFFF_FFF7);
    check("R8 unmask raises irq", {31'd0, irq_o}, 32'd1);
    wr(8'h08, 32'h0000_0004);
    rd(8'h08, 32'h0000_0008, "R9 zero-bit write keeps status");
    wr(8'h08, 32'h0000_0008);
    check("R9 R8 clear drops irq", {31'd0, irq_o}, 32'd0);
    rd(8'h08, 32'h0, "R9 w1c clears");
    bus_addr = 8'h08; bus_wdata = 32'h0000_0010; bus_wr_en = 1'b1;
    hw_status_set = 32'h0000_0010;
    @(negedge clk);
    bus_wr_en = 1'b0; hw_status_set = '0;
    rd(8'h08, 32'h0000_0010, "R10 event beats clear");
    wr(8'h0C, 32'hFFFF_FFEF);
    check("R8 irq for bit 4", {31'd0, irq_o}, 32'd1);

    // R11 misaligned
    wr(8'h01, 32'h0000_0000);
    check("R11 misaligned write ignored", ctrl_o, 32'h6FFF_EFFF);
    rd(8'h02, 32'h0, "R11 misaligned read zero");

    // R6 correct key
    wr(8'h10, 32'h757B_DF0D);
    check("R6 key leaves ctrl", ctrl_o, 32'h6FFF_EFFF);
    rd(8'h00, 32'h6FFF_EFFF, "R6 window still open");

    // R7 wrong key
    wr(8'h10, 32'h1234_5678);
    check("R7 bad key clears fields", ctrl_o, 32'h67FF_E1FF);
    rd(8'h00, 32'h0, "R7 ctrl read blocked");
    rd(8'h0C, 32'h0, "R7 mask read blocked");
    wr(8'h00, 32'h0000_0000);
    check("R7 ctrl write ignored", ctrl_o, 32'h67FF_E1FF);
    wr(8'h0C, 32'hFFFF_FFFF);
    check("R7 mask write ignored irq holds", {31'd0, irq_o}, 32'd1);

    // R1 reset reopens
    do_reset();
    check("R1 ctrl_o after second reset", ctrl_o, 32'h0C00_6000);
    rd(8'h04, 32'h0, "R1 lock cleared by reset");
    rd(8'h00, 32'h0C00_6000, "R1 window reopened");
    @(negedge clk);
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule